// File: doc/BRIEF.md
# Station Address Configuration Image

This block turns a 48-bit network station address into the contents of a small read-only configuration memory. When reset is released it builds the image one entry per clock. Each address byte is stored with its bits mirrored. A check byte follows, so that software reading the window can confirm the contents. Once the image is complete, a ready flag rises and the image is served through a byte-wide read port. That port decodes a 4 KiB address space.

The three most significant address bytes are replaced by the fixed vendor prefix 08:00:07. Only the low 24 bits of the supplied address reach the image, and they are taken during the build cycles only. A self-check request recomputes the parity of the stored entries and reports whether the image is consistent.

Top module: `staddr_prom`

## Requirements
- R1: While reset is held, and on the first sample after it, `ready_o`, `rd_data_o`, `rd_notready_o`, `chk_done_o` and `chk_ok_o` are all 0.
- R2: `ready_o` rises exactly 7 clock edges after reset release (6 address entries plus 1 check entry) and stays high until the next reset.
- R3: Offsets 0 to 5 hold the six effective address bytes, most significant byte at offset 0, each fully bit-reversed (bit 7 swaps with bit 0, bit 6 with bit 1, and so on).
- R4: The upper 24 bits of `station_addr_i` are ignored and replaced by 08:00:07, so offsets 0, 1 and 2 read 0x10, 0x00 and 0xE0.
- R5: Offset 7 holds 0xFF minus the XOR of offsets 0 to 5, which is the bitwise complement of that XOR.
- R6: Offset 6 and every offset from 0x008 to 0xFFF read as 0x00.
- R7: Read data is registered. It changes one clock edge after a cycle with `rd_en_i` high and holds its value in cycles without a read.
- R8: A read issued while `ready_o` is low returns 0x00 and sets `rd_notready_o`. A read issued after ready clears `rd_notready_o`.
- R9: `station_addr_i` is sampled only during the build cycles. It must be stable during those cycles, and changes after `ready_o` have no effect on the image until the next reset.
- R10: One edge after `chk_start_i`, `chk_done_o` pulses for one cycle. `chk_ok_o` is then 1 exactly when the image is built and the XOR of offsets 0 to 5 and 7 equals 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the build |
| station_addr_i | input | 48 | Station address; only bits 23:0 are used |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 12 | Byte offset within the 4 KiB window |
| rd_data_o | output | 8 | Registered read data |
| rd_notready_o | output | 1 | Set when the last read came before the image was ready |
| ready_o | output | 1 | Image complete |
| chk_start_i | input | 1 | Self-check request |
| chk_done_o | output | 1 | One-cycle pulse one edge after a self-check request |
| chk_ok_o | output | 1 | Self-check result |

## Verification
The assertions check the following on every cycle:
- `ready_o` rises on the seventh edge after reset and then stays high.
- Read outputs hold when no read is issued.
- Early reads produce zero data with the not-ready flag set.
- The offset-6 gap reads zero.
- The self-check pulse has the right timing and reports success once the image is built.

The actual byte values depend on the address that was supplied, so only the bench scenarios can show them. These values cover the bit reversal, the forced prefix, the complemented check byte and the zero-filled upper window. The bench also shows that later address changes are ignored and that a new reset builds an image from a new address.

// File: rtl/staddr_prom_pkg.sv
package staddr_prom_pkg;
    localparam int BYTE_W      = 8;
    localparam int N_BYTES     = 6;
    localparam int WIN_ADDR_W  = 12;
    localparam int PREFIX_W    = 24;
    localparam logic [PREFIX_W-1:0] VENDOR_PREFIX = 24'h080007;
    localparam int CHECK_OFFSET = 7;

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sp_bitrev.sv
module sp_bitrev #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign out_o[i] = in_i[W-1-i];
    end
endmodule

// File: rtl/sp_image_builder.sv
module sp_image_builder
    import staddr_prom_pkg::*;
#(
    parameter int N          = N_BYTES,
    parameter int PFX_W      = PREFIX_W,
    parameter logic [PFX_W-1:0] PFX = VENDOR_PREFIX
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [8*N-1:0]           station_addr_i,
    output logic [N-1:0][BYTE_W-1:0] img_o,
    output byte_t                    chk_o,
    output logic                     ready_o
);
    localparam int AW    = 8 * N;
    localparam int IDX_W = $clog2(N + 1);

    typedef struct packed {
        logic [IDX_W-1:0]          idx;
        logic [N-1:0][BYTE_W-1:0]  img;
        byte_t                     acc;
        byte_t                     chk;
        logic                      ready;
    } bld_t;

    bld_t s_d, s_q;
    logic [AW-1:0]            eff_addr;
    logic [N-1:0][BYTE_W-1:0] rev_bytes;

    assign eff_addr = {PFX, station_addr_i[AW-PFX_W-1:0]};

    for (genvar g = 0; g < N; g++) begin : g_rev
        sp_bitrev #(.W(BYTE_W)) u_rev (
            .in_i  (eff_addr[AW-1-BYTE_W*g -: BYTE_W]),
            .out_o (rev_bytes[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (!s_q.ready) begin
            if (s_q.idx < IDX_W'(N)) begin
                s_d.img[s_q.idx] = rev_bytes[s_q.idx];
                s_d.acc          = s_q.acc ^ rev_bytes[s_q.idx];
                s_d.idx          = s_q.idx + 1'b1;
            end else begin
                s_d.chk   = ~s_q.acc;
                s_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign img_o   = s_q.img;
    assign chk_o   = s_q.chk;
    assign ready_o = s_q.ready;
endmodule

// File: rtl/sp_read_port.sv
module sp_read_port
    import staddr_prom_pkg::*;
#(
    parameter int N      = N_BYTES,
    parameter int ADDR_W = WIN_ADDR_W,
    parameter int CHK_OFF = CHECK_OFFSET
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    input  logic [N-1:0][BYTE_W-1:0] img_i,
    input  byte_t                    chk_i,
    input  logic                     ready_i,
    output byte_t                    rd_data_o,
    output logic                     rd_notready_o
);
    localparam int IDX_W = $clog2(N + 1);

    typedef struct packed {
        byte_t data;
        logic  nrdy;
    } rd_t;

    rd_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd_en_i) begin
            if (!ready_i) begin
                r_d.data = '0;
                r_d.nrdy = 1'b1;
            end else begin
                r_d.nrdy = 1'b0;
                if (rd_addr_i < ADDR_W'(N))
                    r_d.data = img_i[rd_addr_i[IDX_W-1:0]];
                else if (rd_addr_i == ADDR_W'(CHK_OFF))
                    r_d.data = chk_i;
                else
                    r_d.data = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data_o     = r_q.data;
    assign rd_notready_o = r_q.nrdy;
endmodule

// File: rtl/sp_selfcheck.sv
module sp_selfcheck
    import staddr_prom_pkg::*;
#(
    parameter int N = N_BYTES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [N-1:0][BYTE_W-1:0] img_i,
    input  byte_t                    chk_i,
    input  logic                     ready_i,
    output logic                     done_o,
    output logic                     ok_o
);
    typedef struct packed {
        logic done;
        logic ok;
    } sc_t;

    sc_t   c_d, c_q;
    byte_t fold;

    always_comb begin
        fold = chk_i;
        for (int i = 0; i < N; i++) fold = fold ^ img_i[i];
    end

    always_comb begin
        c_d      = c_q;
        c_d.done = start_i;
        if (start_i) c_d.ok = ready_i && (fold == 8'hFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign done_o = c_q.done;
    assign ok_o   = c_q.ok;
endmodule

// File: rtl/staddr_prom.sv
module staddr_prom
    import staddr_prom_pkg::*;
#(
    parameter int N      = N_BYTES,
    parameter int ADDR_W = WIN_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [8*N-1:0]    station_addr_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_notready_o,
    output logic              ready_o,
    input  logic              chk_start_i,
    output logic              chk_done_o,
    output logic              chk_ok_o
);
    logic [N-1:0][BYTE_W-1:0] img;
    byte_t                    chk;
    logic                     ready;

    sp_image_builder #(.N(N)) u_build (
        .clk            (clk),
        .rst_n          (rst_n),
        .station_addr_i (station_addr_i),
        .img_o          (img),
        .chk_o          (chk),
        .ready_o        (ready)
    );

    sp_read_port #(.N(N), .ADDR_W(ADDR_W)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_en_i       (rd_en_i),
        .rd_addr_i     (rd_addr_i),
        .img_i         (img),
        .chk_i         (chk),
        .ready_i       (ready),
        .rd_data_o     (rd_data_o),
        .rd_notready_o (rd_notready_o)
    );

    sp_selfcheck #(.N(N)) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (chk_start_i),
        .img_i   (img),
        .chk_i   (chk),
        .ready_i (ready),
        .done_o  (chk_done_o),
        .ok_o    (chk_ok_o)
    );

    assign ready_o = ready;
endmodule

// File: rtl/staddr_prom_checker.sv
module staddr_prom_checker #(
    parameter int N      = 6,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [7:0]        rd_data_o,
    input logic              rd_notready_o,
    input logic              ready_o,
    input logic              chk_start_i,
    input logic              chk_done_o,
    input logic              chk_ok_o
);
    localparam int BUILD = N + 1;
    localparam int CW    = $clog2(BUILD + 2);

    logic [CW-1:0] edges_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     edges_q <= '0;
        else if (edges_q < CW'(BUILD))  edges_q <= edges_q + 1'b1;
    end

    assert_ready_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o == (edges_q >= CW'(BUILD)));

    assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    assert_early_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !ready_o) |=> (rd_data_o == 8'h00 && rd_notready_o));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> ($stable(rd_data_o) && $stable(rd_notready_o)));

    assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && ready_o && rd_addr_i == ADDR_W'(6)) |=> rd_data_o == 8'h00);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start_i |=> chk_done_o);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_start_i |=> !chk_done_o);

    assert_chk_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done_o && ready_o && $past(ready_o)) |-> chk_ok_o);
endmodule

bind staddr_prom staddr_prom_checker #(.N(N), .ADDR_W(ADDR_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en_i       (rd_en_i),
    .rd_addr_i     (rd_addr_i),
    .rd_data_o     (rd_data_o),
    .rd_notready_o (rd_notready_o),
    .ready_o       (ready_o),
    .chk_start_i   (chk_start_i),
    .chk_done_o    (chk_done_o),
    .chk_ok_o      (chk_ok_o)
);

// File: tb/staddr_prom_tb.sv
module staddr_prom_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] station_addr = 48'hAABBCC123456;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_notready;
    logic        ready;
    logic        chk_start = 1'b0;
    logic        chk_done;
    logic        chk_ok;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    staddr_prom u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .station_addr_i (station_addr),
        .rd_en_i        (rd_en),
        .rd_addr_i      (rd_addr),
        .rd_data_o      (rd_data),
        .rd_notready_o  (rd_notready),
        .ready_o        (ready),
        .chk_start_i    (chk_start),
        .chk_done_o     (chk_done),
        .chk_ok_o       (chk_ok)
    );

    // scoreboard queues
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic       fired_q = 1'b0;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
    endfunction

    function automatic logic [7:0] model_byte(input logic [47:0] a, input int off);
        logic [47:0] eff;
        logic [7:0]  x;
        eff = {24'h080007, a[23:0]};
        if (off < 6) return rev8(eff[47-8*off -: 8]);
        if (off == 7) begin
            x = 8'h00;
            for (int i = 0; i < 6; i++) x ^= rev8(eff[47-8*i -: 8]);
            return 8'hFF - x;
        end
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: issue a read at a negedge, push the expected result
    task automatic do_read(input logic [11:0] a, input logic [8:0] exp, input string req);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor
    always @(posedge clk) fired_q <= rd_en;
    always @(negedge clk) begin
        if (fired_q && exp_q.size() > 0) begin
            logic [8:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {23'd0, rd_notready, rd_data}, {23'd0, e});
        end
    end

    task automatic drain();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", ready, 0);
        check("R1 data", rd_data, 0);
        check("R1 nrdy", rd_notready, 0);
        check("R1 chk", {chk_done, chk_ok}, 0);
        rst_n = 1'b1;
        // R8 early read: driven at edge 1, image not ready
        do_read(12'h000, 9'h100, "R8 early read");
        // R10 self-check before ready
        chk_start = 1'b1;
        @(negedge clk);
        chk_start = 1'b0;
        check("R10 early done", chk_done, 1);
        check("R10 early ok", chk_ok, 0);
        // now 3 edges elapsed; wait to 6
        repeat (3) @(negedge clk);
        check("R2 not yet ready at 6", ready, 0);
        @(negedge clk);
        check("R2 ready at 7", ready, 1);
        // R4 prefix and R3 address bytes
        do_read(12'h000, {1'b0, 8'h10}, "R4 off0");
        check("R8 nrdy cleared", rd_notready, 0);
        do_read(12'h001, {1'b0, 8'h00}, "R4 off1");
        do_read(12'h002, {1'b0, 8'hE0}, "R4 off2");
        for (int k = 3; k < 6; k++)
            do_read(12'(k), {1'b0, model_byte(station_addr, k)}, "R3 addr byte");
        do_read(12'h007, {1'b0, model_byte(station_addr, 7)}, "R5 check byte");
        do_read(12'h006, 9'h000, "R6 gap");
        do_read(12'h008, 9'h000, "R6 above");
        do_read(12'hFFF, 9'h000, "R6 top");
        do_read(12'h805, 9'h000, "R6 alias");
        drain();
        // R7: registered data holds without reads
        do_read(12'h003, {1'b0, model_byte(station_addr, 3)}, "R7 load");
        drain();
        held = rd_data;
        rd_addr = 12'h000;
        repeat (3) @(negedge clk);
        check("R7 hold", rd_data, held);
        // R9 late address change ignored
        station_addr = 48'h000000FEDCBA;
        repeat (2) @(negedge clk);
        do_read(12'h005, {1'b0, model_byte(48'hAABBCC123456, 5)}, "R9 ignored");
        // R10 self-check after ready
        @(negedge clk);
        chk_start = 1'b1;
        @(negedge clk);
        chk_start = 1'b0;
        check("R10 done", chk_done, 1);
        check("R10 ok", chk_ok, 1);
        @(negedge clk);
        check("R10 pulse ends", chk_done, 0);
        // new reset builds from new address
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", {ready, rd_data}, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        do_read(12'h003, {1'b0, model_byte(station_addr, 3)}, "R3 rebuild off3");
        do_read(12'h005, {1'b0, model_byte(station_addr, 5)}, "R3 rebuild off5");
        do_read(12'h007, {1'b0, model_byte(station_addr, 7)}, "R5 rebuild check");
        drain();
        check("R3 queue empty", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule